// File: doc/BRIEF.md
# HDLC Receive Frame Buffer

This block sits between the serial receive channel of an HDLC controller and a CPU. The channel hands over one byte per strobe, with flags marking the first and the last byte of each frame. The buffer stores the bytes and counts the length of the frame being received. A frame becomes visible to the CPU only when its last byte has been accepted. At that point the frame's length is queued in a small slot queue, and a level interrupt asks the CPU to collect the frame.

The CPU works through four byte-wide registers behind a request/acknowledge handshake. It reads the head frame's length and then pops its bytes one at a time from the data register. It can also tell the block to throw away the rest of the head frame in one write. When the CPU falls behind, an incoming byte can find the byte store full, or a closing byte can find every length slot taken. In either case the frame being received is removed, a sticky overflow flag is raised, and further bytes are ignored until the next frame start. The byte store depth must be a power of two no larger than 128.

Top module: `hdlc_rx_fbuf`

## Requirements
- R1: After reset, the interrupt is low and the status register (address 3) reads 0. Status bit 0 is ready, bit 1 is overflow and bit 2 is frame-in-progress.
- R2: One cycle after the edge that accepts a byte carrying the end flag, the interrupt and status ready are high. The length register (address 1) then returns the frame's byte count, and while no frame is ready it reads 0.
- R3: Reads of the data register (address 0) return the head frame's bytes in arrival order. After the last byte has been read, ready falls unless another complete frame is queued.
- R4: Up to FRAMES complete frames may be queued. Once the head frame is used up, the next frame's length and bytes are presented.
- R5: Writing a byte with bit 0 set to address 3 while a frame is ready discards the unread remainder of the head frame, and the next frame becomes the head.
- R6: A byte that arrives while DEPTH bytes are stored sets overflow and removes the frame being received. The bytes that follow are ignored until a byte carrying the start flag.
- R7: An end byte that arrives while all FRAMES length slots are occupied also sets overflow and removes that frame. Frames already queued are kept.
- R8: Overflow stays set until a write to address 3 with bit 1 set. If a new overflow occurs in the same cycle as that write, overflow stays set.
- R9: A data read or a drop command issued while no frame is ready changes no state.
- R10: A start byte arriving while a frame is open discards the open frame's bytes and begins a new frame. Bytes without the start flag are ignored while no frame is open.
- R11: The acknowledge goes high in the cycle after a request is accepted and stays high for exactly one cycle. The read data is valid in that cycle.
- R12: The interrupt output always equals the status ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| rx_valid | input | 1 | Byte strobe from the receive channel |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| bus_req | input | 1 | Register access request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address: 0 data, 1 length, 2 reserved, 3 status/control |
| bus_wdata | input | 8 | Write data (address 3: bit 0 drop, bit 1 clear overflow) |
| bus_ack | output | 1 | Access acknowledge, one cycle |
| bus_rdata | output | 8 | Read data, valid with acknowledge |
| irq_ready | output | 1 | Level interrupt: a complete frame waits for transfer |

## Verification
The bench builds the buffer with a 16-byte store and two length slots. With those values the byte-full overflow is reached by a single 17-byte frame, and the slot-full overflow by three one-byte frames. Within a few hundred cycles of mixed traffic the store wraps several times and both overflow causes collide with CPU reads and drops.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_LEN  = 2'd1,
    RA_RSVD = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  localparam int CB_DROP   = 0;
  localparam int CB_OVFCLR = 1;

  typedef struct packed {
    logic [4:0] zero;
    logic       busy;
    logic       ovf;
    logic       ready;
  } status_t;

endpackage

// File: rtl/rfb_mem.sv
module rfb_mem #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cell_q[wr_addr] <= wr_data;
  end

  assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/rfb_lenq.sv
module rfb_lenq #(
  parameter int SLOTS = 4,
  parameter int W = 8,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  localparam logic [PW-1:0] LAST_P = PW'(SLOTS - 1);
  localparam logic [CW-1:0] FULL_C = CW'(SLOTS);

  logic [W-1:0]  slot_q [SLOTS];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == FULL_C);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = slot_q[head_q];
  assign level   = lvl_q;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    lvl_d  = lvl_q;
    if (do_push) tail_d = (tail_q == LAST_P) ? '0 : tail_q + 1'b1;
    if (do_pop)  head_d = (head_q == LAST_P) ? '0 : head_q + 1'b1;
    if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
    else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      lvl_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[tail_q] <= din;
  end

endmodule

// File: rtl/hdlc_rx_fbuf.sv
module hdlc_rx_fbuf #(
  parameter int DEPTH  = 128,
  parameter int FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       bus_ack,
  output logic [7:0] bus_rdata,
  output logic       irq_ready
);
  import rfb_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FRAMES + 1);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

  // registered state
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] part_q, part_d, used_q, used_d, cnt_q, cnt_d;
  logic          in_frm_q, in_frm_d, ovf_q, ovf_d, ack_q;
  logic [7:0]    rdata_q, rdata_d;

  // bus decode
  logic bus_go, rd_en, rd_data_go, ctrl_wr, drop_go, ovf_clr;
  assign bus_go     = bus_req & ~ack_q;
  assign rd_en      = bus_go & ~bus_we;
  assign rd_data_go = rd_en & (bus_addr == RA_DATA);
  assign ctrl_wr    = bus_go & bus_we & (bus_addr == RA_CTRL);
  assign ovf_clr    = ctrl_wr & bus_wdata[CB_OVFCLR];

  // length queue
  logic          frm_rdy, lq_full, lq_empty, lq_pop, len_push;
  logic [LW-1:0] head_len, len_val, remain;
  logic [FW-1:0] lq_cnt;

  rfb_lenq #(.SLOTS(FRAMES), .W(LW)) u_lenq (
    .clk  (clk),
    .rst_n(rst_n),
    .push (len_push),
    .din  (len_val),
    .pop  (lq_pop),
    .dout (head_len),
    .empty(lq_empty),
    .full (lq_full),
    .level(lq_cnt)
  );

  assign frm_rdy = ~lq_empty;
  assign remain  = head_len - used_q;
  assign drop_go = ctrl_wr & bus_wdata[CB_DROP] & frm_rdy;

  // receive side decisions
  logic          rx_take, rx_over, rx_store, pop_byte;
  logic [LW-1:0] keep, eff_cnt, wr_drop, rd_take;
  logic [AW-1:0] eff_wp;
  logic [7:0]    mem_rdata;

  assign rx_take  = rx_valid & (rx_sof | in_frm_q);
  assign keep     = rx_sof ? '0 : part_q;
  assign eff_cnt  = cnt_q - (rx_sof ? part_q : '0);
  assign eff_wp   = wr_ptr_q - (rx_sof ? part_q[AW-1:0] : '0);
  assign rx_over  = rx_take & ((eff_cnt == FULL_L) | (rx_eof & lq_full));
  assign rx_store = rx_take & ~rx_over;
  assign len_push = rx_store & rx_eof;
  assign len_val  = keep + 1'b1;
  assign pop_byte = rd_data_go & frm_rdy;

  rfb_mem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .wr_en  (rx_store),
    .wr_addr(eff_wp),
    .wr_data(rx_data),
    .rd_addr(rd_ptr_q),
    .rd_data(mem_rdata)
  );

  // write-side next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    part_d   = part_q;
    in_frm_d = in_frm_q;
    wr_drop  = '0;
    if (rx_over) begin
      wr_ptr_d = wr_ptr_q - part_q[AW-1:0];
      wr_drop  = part_q;
      part_d   = '0;
      in_frm_d = 1'b0;
    end else if (rx_store) begin
      wr_ptr_d = eff_wp + 1'b1;
      wr_drop  = rx_sof ? part_q : '0;
      if (rx_eof) begin
        part_d   = '0;
        in_frm_d = 1'b0;
      end else begin
        part_d   = keep + 1'b1;
        in_frm_d = 1'b1;
      end
    end
  end

  // read-side next state
  always_comb begin
    rd_ptr_d = rd_ptr_q;
    used_d   = used_q;
    rd_take  = '0;
    lq_pop   = 1'b0;
    if (pop_byte) begin
      rd_ptr_d = rd_ptr_q + 1'b1;
      rd_take  = LW'(1);
      if (used_q + 1'b1 == head_len) begin
        used_d = '0;
        lq_pop = 1'b1;
      end else begin
        used_d = used_q + 1'b1;
      end
    end else if (drop_go) begin
      rd_ptr_d = rd_ptr_q + remain[AW-1:0];
      rd_take  = remain;
      used_d   = '0;
      lq_pop   = 1'b1;
    end
  end

  // shared state and read data
  status_t stat;
  always_comb begin
    stat       = '0;
    stat.ready = frm_rdy;
    stat.ovf   = ovf_q;
    stat.busy  = in_frm_q;
    cnt_d = cnt_q + LW'(rx_store) - wr_drop - rd_take;
    ovf_d = rx_over | (ovf_q & ~ovf_clr);
    case (bus_addr)
      RA_DATA: rdata_d = mem_rdata;
      RA_LEN:  rdata_d = frm_rdy ? 8'(head_len) : 8'h00;
      RA_CTRL: rdata_d = stat;
      default: rdata_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      part_q   <= '0;
      used_q   <= '0;
      cnt_q    <= '0;
      in_frm_q <= 1'b0;
      ovf_q    <= 1'b0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      part_q   <= part_d;
      used_q   <= used_d;
      cnt_q    <= cnt_d;
      in_frm_q <= in_frm_d;
      ovf_q    <= ovf_d;
      ack_q    <= bus_go;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign irq_ready = frm_rdy;

endmodule

// File: rtl/rfb_chk.sv
module rfb_chk #(
  parameter int DEPTH  = 128,
  parameter int FRAMES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(FRAMES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          rx_valid,
  input logic          irq_ready,
  input logic          ovf,
  input logic [LW-1:0] cnt,
  input logic [AW-1:0] rd_ptr,
  input logic [FW-1:0] lq_cnt
);

  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

  logic go;
  assign go = bus_req & ~bus_ack;

  assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> bus_ack);

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(go && bus_we && bus_addr == 2'd3 && bus_wdata[1])) |=> ovf);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rx_valid));

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_L);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !bus_we && bus_addr == 2'd0 && !irq_ready) |=> $stable(rd_ptr));

  assert_drop_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bus_we && bus_addr == 2'd3 && bus_wdata[0] && irq_ready
     && lq_cnt == FW'(1) && !rx_valid) |=> !irq_ready);

endmodule

bind hdlc_rx_fbuf rfb_chk #(.DEPTH(DEPTH), .FRAMES(FRAMES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rx_valid (rx_valid),
  .irq_ready(irq_ready),
  .ovf      (ovf_q),
  .cnt      (cnt_q),
  .rd_ptr   (rd_ptr_q),
  .lq_cnt   (lq_cnt)
);

// File: tb/test_hdlc_rx_fbuf.sv
module test_hdlc_rx_fbuf;

  localparam int DEPTH  = 16;
  localparam int FRAMES = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_ack, irq_ready;
  logic [7:0] bus_rdata;

  always #10 clk = ~clk;

  hdlc_rx_fbuf #(.DEPTH(DEPTH), .FRAMES(FRAMES)) i_hdlc_rx_fbuf (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq_ready(irq_ready)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] bq[$];
  logic [7:0] pq[$];
  int lq[$];
  int used = 0;
  bit infr = 0, movf = 0, mack = 0, exp_chk = 0;
  logic [7:0] exp_rd = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_update();
    bit act, rdy, take, over;
    int pre_lq, pre_cnt, effc;
    act = bus_req && !mack;
    pre_lq = lq.size();
    pre_cnt = bq.size() + pq.size();
    rdy = pre_lq > 0;
    exp_chk = 0;
    if (act && !bus_we) begin
      exp_chk = 1;
      case (bus_addr)
        2'd0: if (rdy) exp_rd = bq[0]; else exp_chk = 0;
        2'd1: exp_rd = rdy ? 8'(lq[0]) : 8'h00;
        2'd3: exp_rd = {5'b0, infr, movf, rdy};
        default: exp_rd = 8'h00;
      endcase
    end
    take = rx_valid && (rx_sof || infr);
    effc = pre_cnt - (rx_sof ? pq.size() : 0);
    over = take && (effc == DEPTH || (rx_eof && pre_lq == FRAMES));
    if (act && !bus_we && bus_addr == 2'd0 && rdy) begin
      void'(bq.pop_front());
      used++;
      if (used == lq[0]) begin void'(lq.pop_front()); used = 0; end
    end
    if (act && bus_we && bus_addr == 2'd3) begin
      if (bus_wdata[1]) movf = 0;
      if (bus_wdata[0] && rdy) begin
        repeat (lq[0] - used) void'(bq.pop_front());
        void'(lq.pop_front());
        used = 0;
      end
    end
    if (over) begin
      pq.delete(); infr = 0; movf = 1;
    end else if (take) begin
      if (rx_sof) pq.delete();
      pq.push_back(rx_data);
      if (rx_eof) begin
        lq.push_back(pq.size());
        foreach (pq[i]) bq.push_back(pq[i]);
        pq.delete();
        infr = 0;
      end else infr = 1;
    end
    mack = act;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(irq_ready == (lq.size() > 0), "R12", irq_ready, lq.size() > 0);
    check(bus_ack == mack, "R11", bus_ack, mack);
    if (mack && exp_chk) check(bus_rdata == exp_rd, cur_req, bus_rdata, exp_rd);
  endtask

  task automatic rx_put(input logic [7:0] d, input bit s, input bit e);
    rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
    step();
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) rx_put(base + 8'(i), i == 0, i == n - 1);
  endtask

  task automatic bus_op(input bit we, input logic [1:0] a, input logic [7:0] wd,
                        output logic [7:0] rd);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    step();
    bus_req = 1'b0;
    rd = bus_rdata;
    step();
  endtask

  logic [7:0] v;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    cur_req = "R1";
    check(irq_ready == 1'b0, "R1", irq_ready, 0);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h00, "R1", v, 0);

    // R2: complete frame raises ready and length
    cur_req = "R2";
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'h00, "R2", v, 0);
    send_frame(8'hA0, 5);
    check(irq_ready == 1'b1, "R2", irq_ready, 1);
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'd5, "R2", v, 5);

    // R3: bytes in order, ready falls after last
    cur_req = "R3";
    for (int i = 0; i < 5; i++) begin
      bus_op(0, 2'd0, 8'h00, v);
      check(v == 8'hA0 + 8'(i), "R3", v, 8'hA0 + i);
    end
    check(irq_ready == 1'b0, "R3", irq_ready, 0);

    // R4: two frames queued
    cur_req = "R4";
    send_frame(8'h10, 3);
    send_frame(8'h20, 2);
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'd3, "R4", v, 3);
    for (int i = 0; i < 3; i++) bus_op(0, 2'd0, 8'h00, v);
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'd2, "R4", v, 2);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'h20, "R4", v, 8'h20);
    bus_op(0, 2'd0, 8'h00, v);

    // R5: drop remainder of head frame
    cur_req = "R5";
    send_frame(8'h30, 4);
    send_frame(8'h40, 2);
    bus_op(0, 2'd0, 8'h00, v);
    bus_op(1, 2'd3, 8'h01, v);
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'd2, "R5", v, 2);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'h40, "R5", v, 8'h40);
    bus_op(1, 2'd3, 8'h01, v);
    check(irq_ready == 1'b0, "R5", irq_ready, 0);

    // R9: empty read and drop have no effect
    cur_req = "R9";
    bus_op(0, 2'd0, 8'h00, v);
    bus_op(1, 2'd3, 8'h01, v);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h00, "R9", v, 0);
    send_frame(8'h50, 2);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'h50, "R9", v, 8'h50);
    bus_op(0, 2'd0, 8'h00, v);

    // R10: idle bytes ignored, start restarts an open frame
    cur_req = "R10";
    rx_put(8'hEE, 0, 0);
    rx_put(8'hEF, 0, 1);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h00, "R10", v, 0);
    rx_put(8'h60, 1, 0);
    rx_put(8'h61, 0, 0);
    send_frame(8'h70, 3);
    bus_op(0, 2'd1, 8'h00, v);
    check(v == 8'd3, "R10", v, 3);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'h70, "R10", v, 8'h70);
    bus_op(1, 2'd3, 8'h01, v);

    // R6: byte store overflow
    cur_req = "R6";
    send_frame(8'h80, DEPTH + 2);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h02, "R6", v, 2);
    rx_put(8'h99, 0, 1);
    check(irq_ready == 1'b0, "R6", irq_ready, 0);

    // R8: overflow sticky until cleared
    cur_req = "R8";
    bus_op(0, 2'd1, 8'h00, v);
    bus_op(0, 2'd3, 8'h00, v);
    check(v[1] == 1'b1, "R8", v, 2);
    bus_op(1, 2'd3, 8'h02, v);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h00, "R8", v, 0);

    // R7: length slot overflow
    cur_req = "R7";
    send_frame(8'hB0, 1);
    send_frame(8'hB1, 1);
    send_frame(8'hB2, 1);
    bus_op(0, 2'd3, 8'h00, v);
    check(v == 8'h03, "R7", v, 3);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'hB0, "R7", v, 8'hB0);
    bus_op(0, 2'd0, 8'h00, v);
    check(v == 8'hB1, "R7", v, 8'hB1);
    bus_op(1, 2'd3, 8'h02, v);

    // R4: mixed traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 800; i++) begin
      rx_valid = ($urandom % 2) == 0;
      rx_data  = 8'($urandom);
      rx_sof   = ($urandom % 6) == 0;
      rx_eof   = ($urandom % 5) == 0;
      if (!bus_ack && ($urandom % 3) == 0) begin
        bus_req  = 1'b1;
        bus_we   = ($urandom % 4) == 0;
        bus_addr = 2'($urandom);
        bus_wdata = 8'($urandom % 4);
      end else bus_req = 1'b0;
      step();
    end
    rx_valid = 1'b0; bus_req = 1'b0;
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule